// File: doc/BRIEF.md
# Flash Page Load and Read Sequencer for a JTAG Test Port

This block sits behind a JTAG test access port and turns three programming instructions into traffic for a flash programming back end. Under the command instruction it holds a 15-bit data register. Capture-DR loads this register with the result of the previous command. Shift-DR moves it one bit per TCK. Update-DR hands the shifted word to the flash side, and a Run-Test/Idle cycle executes it. A command word with its top bit set also loads the 14-bit word address.

Under the load and read instructions, only the low byte of the same register is reachable. Data moves one byte at a time, but addresses count 16-bit words. Each load Update-DR writes one byte lane into the page buffer one TCK later. Each read Capture-DR picks one byte lane from the word at the current address. The lane alternates low, high, low, and so on. The word address advances before a low-byte write (except the first one after entry) and after every high-byte read.

The TAP state machine sits outside the block. It supplies one-cycle strobes for Capture-DR, Shift-DR, Update-DR and Run-Test/Idle, together with the decoded instruction.

Top module: `jtag_page_seq`

## Requirements
- R1: While trst_n is low and right after its release, cmd_word, cmd_valid, pb_we, pb_hi, pb_data, tdo and rd_addr are all zero.
- R2: With instruction 0x5, cap_dr loads the 15-bit register from cmd_result. Each shf_dr cycle shifts tdi in at bit 14, LSB first, and tdo shows bit 0 during that cycle.
- R3: With instruction 0x5, upd_dr makes cmd_word equal the register and raises cmd_valid for exactly the next cycle. If bit 14 of the register is 1, rd_addr takes bits 13:0; otherwise rd_addr is kept.
- R4: cmd_run is high in the same cycle as rti when the instruction is 0x5, and low under any other instruction.
- R5: With instruction 0x6 or 0x7, shf_dr shifts only bits 7:0 (tdi in at bit 7, tdo shows bit 0), and bits 14:8 keep their value.
- R6: With instruction 0x6, each upd_dr causes pb_we to be high for the following cycle, with pb_data equal to the shifted byte. pb_hi is 0 for the first such write after entering 0x6 and then alternates.
- R7: With instruction 0x6, the word address is incremented before each low-byte write except the first after entry. pb_addr carries that address. Filling the last word of a page leaves rd_addr on that word.
- R8: With instruction 0x7, cap_dr loads bits 7:0 from rd_data[7:0] or rd_data[15:8], starting with the low byte after entry and alternating.
- R9: With instruction 0x7, rd_addr increments after each high-byte capture, including the first one. Reading the last word of a page leaves rd_addr on the first word of the next page.
- R10: Entering 0x6 or 0x7 from another instruction restarts the lane at low and re-arms the first-byte rule without changing the address. The address wraps from 0x3FFF to 0.
- R11: Under any other instruction, the strobes have no effect: no write, no cmd_valid, tdo stays 0 and the address is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 4 | Currently decoded instruction |
| cap_dr | input | 1 | Capture-DR state strobe |
| shf_dr | input | 1 | Shift-DR state strobe |
| upd_dr | input | 1 | Update-DR state strobe |
| rti | input | 1 | Run-Test/Idle state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| cmd_result | input | 15 | Result of the previous command |
| cmd_word | output | 15 | Command applied to the flash side |
| cmd_valid | output | 1 | One-cycle pulse when cmd_word is applied |
| cmd_run | output | 1 | Execute cycle for the applied command |
| pb_we | output | 1 | Page-buffer byte write strobe |
| pb_addr | output | 14 | Page-buffer word address |
| pb_hi | output | 1 | Page-buffer byte lane, 1 for the high byte |
| pb_data | output | 8 | Page-buffer write byte |
| rd_addr | output | 14 | Flash read word address (current word address) |
| rd_data | input | 16 | Flash read word at rd_addr |

## Verification
The bench fills the last word of a page and checks that the address stays on it. A design that pre-incremented on every low byte would skip the first word, and one that post-incremented would step into the next page. It reads across a page end and checks that the address lands in the next page, which catches an increment on the wrong lane. It leaves the load instruction after a single low byte and re-enters it, then expects a low byte at the same word; a stale lane toggle would write the high byte, and a stale first flag would skip a word. It also shifts under the byte view and then reads the whole register under the command view, so any corruption of the upper seven bits shows up. Finally, it drives wrap at the top address and strobes under an unrelated instruction.

// File: rtl/jtag_page_seq.sv
module jtag_page_seq #(
  parameter int IR_W     = 4,
  parameter int CMD_W    = 15,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 14,
  parameter int INS_CMD  = 5,
  parameter int INS_LOAD = 6,
  parameter int INS_READ = 7
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              cap_dr,
  input  logic              shf_dr,
  input  logic              upd_dr,
  input  logic              rti,
  input  logic              tdi,
  output logic              tdo,
  input  logic [CMD_W-1:0]  cmd_result,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_valid,
  output logic              cmd_run,
  output logic              pb_we,
  output logic [ADDR_W-1:0] pb_addr,
  output logic              pb_hi,
  output logic [BYTE_W-1:0] pb_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [2*BYTE_W-1:0] rd_data
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [CMD_W-1:0]  sr;
  logic [IR_W-1:0]   ir_q;
  logic              lane_hi;
  logic              first_byte;
  logic [ADDR_W-1:0] word_addr;

  wire sel_cmd  = (ir_code == IR_W'(INS_CMD));
  wire sel_load = (ir_code == IR_W'(INS_LOAD));
  wire sel_read = (ir_code == IR_W'(INS_READ));
  wire sel_byte = sel_load | sel_read;
  wire entering = sel_byte && (ir_code != ir_q);

  wire [ADDR_W-1:0] addr_inc = word_addr + 1'b1;
  wire [ADDR_W-1:0] load_tgt = (!lane_hi && !first_byte) ? addr_inc : word_addr;
  wire [BYTE_W-1:0] rd_byte  = lane_hi ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0];

  assign tdo     = shf_dr && (sel_cmd || sel_byte) ? sr[0] : 1'b0;
  assign cmd_run = rti & sel_cmd;
  assign rd_addr = word_addr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr         <= '0;
      ir_q       <= '0;
      lane_hi    <= 1'b0;
      first_byte <= 1'b1;
      word_addr  <= '0;
      cmd_word   <= '0;
      cmd_valid  <= 1'b0;
      pb_we      <= 1'b0;
      pb_addr    <= '0;
      pb_hi      <= 1'b0;
      pb_data    <= '0;
    end else begin
      ir_q      <= ir_code;
      cmd_valid <= 1'b0;
      pb_we     <= 1'b0;
      if (entering) begin
        lane_hi    <= 1'b0;
        first_byte <= 1'b1;
      end
      if (sel_cmd) begin
        if (cap_dr)      sr <= cmd_result;
        else if (shf_dr) sr <= {tdi, sr[CMD_W-1:1]};
        if (upd_dr) begin
          cmd_word  <= sr;
          cmd_valid <= 1'b1;
          if (sr[CMD_W-1]) word_addr <= sr[ADDR_W-1:0];
        end
      end else if (sel_load) begin
        if (shf_dr) sr[BYTE_W-1:0] <= {tdi, sr[BYTE_W-1:1]};
        if (upd_dr) begin
          pb_data    <= sr[BYTE_W-1:0];
          pb_we      <= 1'b1;
          pb_addr    <= load_tgt;
          pb_hi      <= lane_hi;
          word_addr  <= load_tgt;
          lane_hi    <= ~lane_hi;
          first_byte <= 1'b0;
        end
      end else if (sel_read) begin
        if (cap_dr) begin
          sr[BYTE_W-1:0] <= rd_byte;
          if (lane_hi) word_addr <= addr_inc;
          lane_hi <= ~lane_hi;
        end else if (shf_dr) begin
          sr[BYTE_W-1:0] <= {tdi, sr[BYTE_W-1:1]};
        end
      end
    end
  end

  AST_CMD_VALID_PULSE: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_dr && sel_cmd) |=> (cmd_valid && cmd_word == $past(sr))); // R3
  AST_VALID_SOURCE: assert property (@(posedge tck) disable iff (!trst_n)
    cmd_valid |-> $past(upd_dr && sel_cmd)); // R11
  AST_UPPER_KEPT: assert property (@(posedge tck) disable iff (!trst_n)
    (sel_byte && shf_dr) |=> $stable(sr[CMD_W-1:BYTE_W])); // R5
  AST_WR_NEXT_CYCLE: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_dr && sel_load) |=> (pb_we && pb_data == $past(sr[BYTE_W-1:0]))); // R6
  AST_WR_SOURCE: assert property (@(posedge tck) disable iff (!trst_n)
    pb_we |-> $past(upd_dr && sel_load)); // R11
  AST_RD_ADDR_STEP: assert property (@(posedge tck) disable iff (!trst_n)
    (cap_dr && sel_read) |=> (rd_addr == $past(rd_addr) || rd_addr == $past(rd_addr) + 1'b1)); // R9
  AST_LOAD_ADDR_STEP: assert property (@(posedge tck) disable iff (!trst_n)
    pb_we |-> (pb_addr == $past(rd_addr) || pb_addr == $past(rd_addr) + 1'b1)); // R7
endmodule

// File: tb/jtag_page_seq_bench.sv
module jtag_page_seq_bench;
  localparam int TCK_PERIOD = 10;
  localparam int PAGE_WORDS = 64;

  logic tck = 0, trst_n = 0;
  logic [3:0] ir_code = 0;
  logic cap_dr = 0, shf_dr = 0, upd_dr = 0, rti = 0, tdi = 0;
  logic tdo;
  logic [14:0] cmd_result = 0;
  logic [14:0] cmd_word;
  logic cmd_valid, cmd_run, pb_we, pb_hi;
  logic [13:0] pb_addr, rd_addr;
  logic [7:0] pb_data;
  logic [15:0] rd_data;

  int n_chk = 0, n_fail = 0;

  function automatic logic [15:0] mem_word(input logic [13:0] a);
    return {a[7:0] ^ 8'hC3, a[13:6]};
  endfunction
  assign rd_data = mem_word(rd_addr);

  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_page_seq u_jtag_page_seq (
    .tck(tck), .trst_n(trst_n), .ir_code(ir_code), .cap_dr(cap_dr), .shf_dr(shf_dr),
    .upd_dr(upd_dr), .rti(rti), .tdi(tdi), .tdo(tdo), .cmd_result(cmd_result),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .cmd_run(cmd_run), .pb_we(pb_we),
    .pb_addr(pb_addr), .pb_hi(pb_hi), .pb_data(pb_data), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_ir(input logic [3:0] c);
    ir_code = c;
    @(negedge tck);
  endtask

  task automatic shift(input int n, input logic [14:0] v, output logic [14:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      tdi = v[i]; shf_dr = 1;
      #1 got[i] = tdo;
      @(negedge tck);
    end
    shf_dr = 0; tdi = 0;
  endtask

  task automatic do_update();
    upd_dr = 1; @(negedge tck); upd_dr = 0;
  endtask

  task automatic do_capture();
    cap_dr = 1; @(negedge tck); cap_dr = 0;
  endtask

  task automatic set_addr(input logic [13:0] a);
    logic [14:0] g;
    set_ir(4'h5);
    shift(15, {1'b1, a}, g);
    do_update();
  endtask

  task automatic load_byte(input logic [7:0] b, input logic [13:0] ea, input bit eh, input string req);
    logic [14:0] g;
    shift(8, {7'd0, b}, g);
    upd_dr = 1; @(negedge tck); upd_dr = 0;
    chk(pb_we === 1'b1, req, "pb_we", pb_we, 1);
    chk(pb_data === b, req, "pb_data", pb_data, b);
    chk(pb_addr === ea, req, "pb_addr", pb_addr, ea);
    chk(pb_hi === eh, req, "pb_hi", pb_hi, eh);
    @(negedge tck);
    chk(pb_we === 1'b0, req, "pb_we drop", pb_we, 0);
  endtask

  task automatic read_byte(input logic [7:0] eb, input string req);
    logic [14:0] g;
    do_capture();
    shift(8, 15'h0, g);
    chk(g[7:0] === eb, req, "read byte", g[7:0], eb);
  endtask

  task automatic t_reset();
    chk(cmd_word === 0 && cmd_valid === 0, "R1", "cmd outputs", {cmd_word, cmd_valid}, 0);
    chk(pb_we === 0 && pb_hi === 0 && pb_data === 0, "R1", "pb outputs", {pb_we, pb_hi, pb_data}, 0);
    chk(tdo === 0 && rd_addr === 0, "R1", "tdo/addr", {tdo, rd_addr}, 0);
  endtask

  task automatic t_command();
    logic [14:0] g;
    set_ir(4'h5);
    cmd_result = 15'h2ABC;
    do_capture();
    shift(15, 15'h1234, g);
    chk(g === 15'h2ABC, "R2", "shifted result", g, 15'h2ABC);
    upd_dr = 1; @(negedge tck); upd_dr = 0;
    chk(cmd_valid === 1 && cmd_word === 15'h1234, "R3", "applied cmd", cmd_word, 15'h1234);
    chk(rd_addr === 0, "R3", "addr kept", rd_addr, 0);
    @(negedge tck);
    chk(cmd_valid === 0, "R3", "valid one cycle", cmd_valid, 0);
    rti = 1; #1;
    chk(cmd_run === 1, "R4", "run in cmd", cmd_run, 1);
    @(negedge tck); rti = 0;
    set_addr(14'h0040);
    chk(rd_addr === 14'h0040, "R3", "addr load", rd_addr, 14'h40);
  endtask

  task automatic t_load();
    logic [14:0] g;
    set_ir(4'h6);
    rti = 1; #1;
    chk(cmd_run === 0, "R4", "no run in load", cmd_run, 0);
    @(negedge tck); rti = 0;
    load_byte(8'h11, 14'h0040, 0, "R6");
    load_byte(8'h22, 14'h0040, 1, "R6");
    load_byte(8'h33, 14'h0041, 0, "R7");
    set_addr(14'h007E);
    set_ir(4'h6);
    load_byte(8'hA1, 14'h007E, 0, "R7");
    load_byte(8'hA2, 14'h007E, 1, "R7");
    load_byte(8'hA3, 14'h007F, 0, "R7");
    load_byte(8'hA4, 14'h007F, 1, "R7");
    chk(rd_addr === 14'(2*PAGE_WORDS-1), "R7", "page end kept", rd_addr, 2*PAGE_WORDS-1);
    set_ir(4'h5);
    shift(15, 15'h0, g);
    chk(g === {1'b1, 6'd0, 8'hA4}, "R5", "upper bits kept", g, {1'b1, 6'd0, 8'hA4});
  endtask

  task automatic t_reenter_and_ignore();
    logic [14:0] g;
    set_addr(14'h0100);
    set_ir(4'h6);
    load_byte(8'h5A, 14'h0100, 0, "R10");
    set_ir(4'hF);
    cmd_result = 15'h7FFF;
    do_capture();
    shift(4, 15'hF, g);
    chk(g[3:0] === 4'h0, "R11", "tdo idle", g[3:0], 0);
    upd_dr = 1; @(negedge tck); upd_dr = 0;
    chk(pb_we === 0 && cmd_valid === 0, "R11", "no strobes", {pb_we, cmd_valid}, 0);
    chk(rd_addr === 14'h0100, "R11", "addr kept", rd_addr, 14'h100);
    set_ir(4'h6);
    load_byte(8'h6B, 14'h0100, 0, "R10");
    load_byte(8'h7C, 14'h0100, 1, "R10");
  endtask

  task automatic t_read();
    logic [13:0] a;
    a = 14'(PAGE_WORDS-1);
    set_addr(a);
    set_ir(4'h7);
    read_byte(mem_word(a)[7:0], "R8");
    chk(rd_addr === a, "R9", "no step after low", rd_addr, a);
    read_byte(mem_word(a)[15:8], "R8");
    chk(rd_addr === 14'(PAGE_WORDS), "R9", "next page", rd_addr, PAGE_WORDS);
    read_byte(mem_word(14'(PAGE_WORDS))[7:0], "R8");
  endtask

  task automatic t_wrap();
    set_addr(14'h3FFF);
    set_ir(4'h7);
    read_byte(mem_word(14'h3FFF)[7:0], "R8");
    read_byte(mem_word(14'h3FFF)[15:8], "R8");
    chk(rd_addr === 0, "R10", "read wrap", rd_addr, 0);
    set_addr(14'h3FFF);
    set_ir(4'h6);
    load_byte(8'h01, 14'h3FFF, 0, "R10");
    load_byte(8'h02, 14'h3FFF, 1, "R10");
    load_byte(8'h03, 14'h0000, 0, "R10");
  endtask

  initial begin
    #(TCK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge tck);
    t_reset();
    trst_n = 1;
    @(negedge tck);
    t_reset();
    t_command();
    t_load();
    t_reenter_and_ignore();
    t_read();
    t_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule